// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM whose bus never needs an idle cycle when it changes direction. Each rising clock edge with the clock enable active samples one command: address, read/write select, per-lane write enables, three chip selects and a load/advance select. The data transfer for that command takes place exactly two enabled cycles later. Reads and writes can therefore be interleaved on every cycle, and the data bus carries one transfer per cycle in either direction.

The data bus is presented as three separate ports: `d_in` for write data, `d_out` for read data, and `d_oe` as the output-drive qualifier. A load command opens a four-word burst. Advance cycles then step through the burst in linear or interleaved order and keep the read/write type of the load. Holding the clock enable inactive freezes every register, including transfers already in flight. The output enable acts at once, with no clock edge needed.

A small state machine tracks the open burst. It has three states:
- `ST_IDLE`: no burst open.
- `ST_RD_BURST`: a read burst is open.
- `ST_WR_BURST`: a write burst is open.

Its transitions are:
- LOAD_RD: load with all selects active and `wr_n` high; goes to `ST_RD_BURST` from any state.
- LOAD_WR: the same with `wr_n` low; goes to `ST_WR_BURST`.
- DESELECT: load with any select inactive; goes to `ST_IDLE` from any state.
- ADVANCE: `adv` high; keeps the state and steps the burst counter when a burst is open.
- STALL: `clk_en_n` high; keeps everything.

Top module: `noturn_sram`

## Requirements
- R1: A read command sampled at an enabled edge drives `d_out` with the stored word and raises `d_oe` for the whole second enabled cycle after the command cycle. A write command takes `d_in` at the end of its second enabled cycle after the command cycle.
- R2: Commands may alternate between read and write on consecutive cycles. A read issued in the cycle right after a write to the same address returns the newly written lanes.
- R3: While `clk_en_n` is high, all other synchronous inputs are ignored and `d_out`/`d_oe` hold. A pending write keeps its slot and takes `d_in` at the next enabled edge, so `d_in` presented during the stall is not stored.
- R4: A new operation starts only when `adv` is 0 and all three `chip_sel_n` bits are 0. `adv` = 0 with any `chip_sel_n` bit at 1 is a deselect and has no data phase.
- R5: `d_oe` is 0 in the data-phase cycle of a write, a deselect or a no-op.
- R6: `out_en_n` = 1 forces `d_oe` to 0 at once, with no clock edge. Returning it to 0 restores the pipelined drive value.
- R7: `adv` = 1 continues the open burst with the read/write type of its load; `wr_n` is ignored in advance cycles.
- R8: `seq_lin` is captured at the load. For the n-th advance after a load at address A, the address has the upper bits of A. Its low two bits are (A[1:0] + n) mod 4 when `seq_lin` = 1, and A[1:0] XOR (n mod 4) when `seq_lin` = 0.
- R9: After the fourth word the burst wraps to its starting word and keeps stepping while `adv` stays 1.
- R10: Lane i is bits [9i+8:9i]. It is written only when `lane_we_n[i]` was 0 in that command cycle; this applies to advance cycles too. Lanes not written keep their contents.
- R11: An advance cycle with no open burst (after reset or a deselect) is a no-op and leaves `d_oe` at 0.
- R12: Reset (`rst_n` low, asynchronous) clears the pipeline and the burst state, and forces `d_oe` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| chip_sel_n | input | 3 | Three chip selects, all active low |
| adv | input | 1 | 0 loads a new command, 1 advances the open burst |
| wr_n | input | 1 | 0 write, 1 read (sampled on loads) |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data bus |
| d_out | output | LANES*LANE_W | Read data bus |
| d_oe | output | 1 | High when the block drives the data bus |

## Verification
The bench builds the block with its defaults: ADDR_W = 10, LANES = 4 and LANE_W = 9. Four lanes make partial masks such as 1010 and 0011 meaningful. The nine-bit lanes show that the parity position is stored like any other data bit. Ten address bits leave room for bursts that start at every low-address offset, in both orders, without any alias, so each wrap and each interleave step lands on a distinct, known word.

// File: rtl/nts_pkg.sv
package nts_pkg;

    // Command kinds carried down the two-stage pipeline
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_t;

    // Burst tracker states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } burst_st_t;

    localparam int BURST_W = 2;

    // Low address bits of a burst word: linear adds, interleaved XORs
    function automatic logic [BURST_W-1:0] burst_slot(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               linear
    );
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/nts_burst_fsm.sv
module nts_burst_fsm
    import nts_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              wr_n,
    input  logic              seq_lin,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] cmd_addr
);

    burst_st_t          state_q;
    burst_st_t          state_d;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;
    logic               lin_q;
    logic               load_ok;

    assign load_ok = !adv && sel_ok;
    assign cnt_nx  = cnt_q + BURST_W'(1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ok) state_d = wr_n ? ST_RD_BURST : ST_WR_BURST;
            end
            ST_RD_BURST, ST_WR_BURST: begin
                if (!adv) state_d = load_ok ? (wr_n ? ST_RD_BURST : ST_WR_BURST) : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= ST_IDLE;
        else if (step) state_q <= state_d;
    end

    // Burst base, counter and order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b1;
        end else if (step) begin
            if (load_ok) begin
                base_q <= addr;
                cnt_q  <= '0;
                lin_q  <= seq_lin;
            end else if (adv && state_q != ST_IDLE) begin
                cnt_q <= cnt_nx;
            end
        end
    end

    // Command outputs
    always_comb begin
        cmd      = CMD_NONE;
        cmd_addr = addr;
        if (!adv) begin
            if (sel_ok) cmd = wr_n ? CMD_RD : CMD_WR;
        end else begin
            unique case (state_q)
                ST_IDLE: cmd = CMD_NONE;
                ST_RD_BURST: begin
                    cmd      = CMD_RD;
                    cmd_addr = {base_q[ADDR_W-1:BURST_W], burst_slot(base_q[BURST_W-1:0], cnt_nx, lin_q)};
                end
                ST_WR_BURST: begin
                    cmd      = CMD_WR;
                    cmd_addr = {base_q[ADDR_W-1:BURST_W], burst_slot(base_q[BURST_W-1:0], cnt_nx, lin_q)};
                end
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/nts_pipe.sv
module nts_pipe
    import nts_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LANES-1:0]  cmd_we,
    input  logic [DATA_W-1:0] d_in,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [LANES-1:0]  mem_wr_lane,
    output logic              drv_q,
    output logic [DATA_W-1:0] dq_q
);

    cmd_t              k1_q, k2_q;
    logic [ADDR_W-1:0] a1_q, a2_q;
    logic [LANES-1:0]  we1_q, we2_q;
    logic              wr_now;
    logic              hit;
    logic [DATA_W-1:0] fwd;

    // Command stages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k1_q <= CMD_NONE;
            k2_q <= CMD_NONE;
        end else if (step) begin
            k1_q <= cmd;
            k2_q <= k1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (step) begin
            a1_q  <= cmd_addr;
            we1_q <= cmd_we;
            a2_q  <= a1_q;
            we2_q <= we1_q;
        end
    end

    assign wr_now      = step && (k2_q == CMD_WR);
    assign hit         = (k2_q == CMD_WR) && (a2_q == a1_q);
    assign mem_rd_addr = a1_q;
    assign mem_wr_addr = a2_q;

    // Per-lane write strobes and write-to-read forwarding
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_wr_lane[g] = wr_now && we2_q[g];
        assign fwd[g*LANE_W +: LANE_W] = (hit && we2_q[g]) ? d_in[g*LANE_W +: LANE_W]
                                                           : mem_rd_data[g*LANE_W +: LANE_W];
    end

    // Output register: loaded one enabled edge before the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
            dq_q  <= '0;
        end else if (step) begin
            drv_q <= (k1_q == CMD_RD);
            if (k1_q == CMD_RD) dq_q <= fwd;
        end
    end

endmodule

// File: rtl/nts_lane_ram.sv
module nts_lane_ram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/noturn_sram.sv
module noturn_sram
    import nts_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic [2:0]        chip_sel_n,
    input  logic              adv,
    input  logic              wr_n,
    input  logic              seq_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe
);

    logic              step;
    logic              sel_ok;
    cmd_t              cmd;
    logic [ADDR_W-1:0] cmd_addr;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [LANES-1:0]  mem_wr_lane;
    logic [DATA_W-1:0] mem_rd_data;
    logic              drv_q;

    assign step   = !clk_en_n;
    assign sel_ok = (chip_sel_n == 3'b000);

    nts_burst_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sel_ok   (sel_ok),
        .adv      (adv),
        .wr_n     (wr_n),
        .seq_lin  (seq_lin),
        .addr     (addr),
        .cmd      (cmd),
        .cmd_addr (cmd_addr)
    );

    nts_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .cmd         (cmd),
        .cmd_addr    (cmd_addr),
        .cmd_we      (~lane_we_n),
        .d_in        (d_in),
        .mem_rd_data (mem_rd_data),
        .mem_rd_addr (mem_rd_addr),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_lane (mem_wr_lane),
        .drv_q       (drv_q),
        .dq_q        (d_out)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_ram
        nts_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (mem_wr_lane[g]),
            .waddr (mem_wr_addr),
            .wdata (d_in[g*LANE_W +: LANE_W]),
            .raddr (mem_rd_addr),
            .rdata (mem_rd_data[g*LANE_W +: LANE_W])
        );
    end

    // Asynchronous output gate
    assign d_oe = drv_q && !out_en_n;

endmodule

// File: rtl/noturn_sram_chk.sv
module noturn_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic [2:0]        chip_sel_n,
    input logic              adv,
    input logic              wr_n,
    input logic              out_en_n,
    input logic              d_oe,
    input logic [DATA_W-1:0] d_out
);

    // Independent history of command kinds: 0 none, 1 read, 2 write
    logic [1:0] h1_q, h2_q, now_k;
    logic       open_q, open_wr_q;

    always_comb begin
        if (!adv)       now_k = (chip_sel_n == 3'b000) ? (wr_n ? 2'd1 : 2'd2) : 2'd0;
        else if (open_q) now_k = open_wr_q ? 2'd2 : 2'd1;
        else            now_k = 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1_q      <= 2'd0;
            h2_q      <= 2'd0;
            open_q    <= 1'b0;
            open_wr_q <= 1'b0;
        end else if (!clk_en_n) begin
            h1_q <= now_k;
            h2_q <= h1_q;
            if (!adv) begin
                open_q    <= (chip_sel_n == 3'b000);
                open_wr_q <= !wr_n;
            end
        end
    end

    // R1: read data phase drives the bus
    p_rd_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (h2_q == 2'd1 && !out_en_n) |-> d_oe);

    // R5 (covers R4, R11): any other data phase leaves the bus undriven
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (h2_q != 2'd1) |-> !d_oe);

    // R6: output enable gates the drive
    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !d_oe);

    // R3: a stalled edge changes nothing on the outputs
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !out_en_n) |=> ($stable(d_out) && (d_oe == $past(d_oe) || out_en_n)));

endmodule

bind noturn_sram noturn_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .chip_sel_n (chip_sel_n),
    .adv        (adv),
    .wr_n       (wr_n),
    .out_en_n   (out_en_n),
    .d_oe       (d_oe),
    .d_out      (d_out)
);

// File: tb/sim_noturn_sram.sv
module sim_noturn_sram;

    localparam int AW = 10;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic [2:0]    chip_sel_n = 3'b111;
    logic          adv = 1'b0;
    logic          wr_n = 1'b1;
    logic          seq_lin = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_we_n = '1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] d_out;
    logic          d_oe;

    noturn_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .chip_sel_n(chip_sel_n),
        .adv(adv), .wr_n(wr_n), .seq_lin(seq_lin), .addr(addr), .lane_we_n(lane_we_n),
        .out_en_n(out_en_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Vector: [24:21] requirement, [20] stall, [19:17] sel_n, [16] adv,
    //         [15] wr_n, [14] seq_lin, [13:4] addr, [3:0] lane_we_n
    typedef logic [24:0] vec_t;

    function automatic vec_t v_ld(int tg, bit wr, logic [9:0] a, bit lin, logic [3:0] ben);
        return {4'(tg), 1'b0, 3'b000, 1'b0, ~wr, lin, a, ben};
    endfunction
    function automatic vec_t v_adv(int tg, logic [3:0] ben, bit wrn);
        return {4'(tg), 1'b0, 3'b000, 1'b1, wrn, 1'b1, 10'h000, ben};
    endfunction
    function automatic vec_t v_sel(int tg, logic [2:0] sn, logic [9:0] a);
        return {4'(tg), 1'b0, sn, 1'b0, 1'b1, 1'b1, a, 4'hF};
    endfunction
    function automatic vec_t v_stall(int tg);
        return {4'(tg), 1'b1, 3'b000, 1'b0, 1'b0, 1'b1, 10'h3FF, 4'h0};
    endfunction

    localparam int NV = 47;
    localparam vec_t TBL [NV] = '{
        v_ld(5, 1, 10'h010, 1, 4'h0),   // R5 write, bus off in its data phase
        v_ld(2, 0, 10'h010, 1, 4'hF),   // R2 read right after write, same word
        v_ld(5, 1, 10'h011, 1, 4'h0),
        v_ld(2, 0, 10'h011, 1, 4'hF),
        v_ld(5, 1, 10'h012, 1, 4'h0),
        v_ld(5, 1, 10'h013, 1, 4'h0),
        v_ld(1, 0, 10'h012, 1, 4'hF),   // R1 two-cycle read latency
        v_ld(1, 0, 10'h013, 1, 4'hF),
        v_ld(7, 1, 10'h020, 1, 4'h0),   // R7 write burst, wr_n high in advances
        v_adv(7, 4'h0, 1'b1),
        v_adv(7, 4'h0, 1'b1),
        v_adv(7, 4'h0, 1'b1),
        v_ld(8, 0, 10'h022, 0, 4'hF),   // R8 interleaved read 22 23 20 21
        v_adv(8, 4'hF, 1'b0),
        v_adv(8, 4'hF, 1'b0),
        v_adv(8, 4'hF, 1'b0),
        v_adv(9, 4'hF, 1'b0),           // R9 wrap back to 22
        v_ld(8, 0, 10'h021, 1, 4'hF),   // R8 linear read 21 22 23 20
        v_adv(8, 4'hF, 1'b1),
        v_adv(8, 4'hF, 1'b1),
        v_adv(8, 4'hF, 1'b1),
        v_ld(7, 1, 10'h031, 0, 4'h0),   // interleaved write 31 30 33 32
        v_adv(7, 4'h0, 1'b1),
        v_adv(7, 4'h0, 1'b1),
        v_adv(7, 4'h0, 1'b1),
        v_ld(8, 0, 10'h030, 1, 4'hF),   // linear read 30..33
        v_adv(8, 4'hF, 1'b1),
        v_adv(8, 4'hF, 1'b1),
        v_adv(8, 4'hF, 1'b1),
        v_adv(9, 4'hF, 1'b1),           // wrap back to 30
        v_ld(10, 1, 10'h010, 1, 4'b1010), // R10 lanes 0 and 2 only
        v_sel(4, 3'b111, 10'h010),      // R4 deselect
        v_ld(10, 0, 10'h010, 1, 4'hF),
        v_adv(7, 4'hF, 1'b0),           // read burst stays a read: 0x011
        v_sel(4, 3'b100, 10'h011),
        v_adv(11, 4'h0, 1'b0),          // R11 advance after deselect
        v_sel(4, 3'b001, 10'h011),      // one select off: deselect
        v_ld(3, 0, 10'h012, 1, 4'hF),   // R3 stall with read in flight
        v_stall(3),
        v_stall(3),
        v_ld(3, 1, 10'h013, 1, 4'b0011),
        v_ld(3, 0, 10'h012, 1, 4'hF),
        v_stall(3),                     // stall in write data phase
        v_ld(3, 0, 10'h013, 1, 4'hF),
        v_sel(4, 3'b111, 10'h000),
        v_sel(4, 3'b111, 10'h000),
        v_sel(4, 3'b111, 10'h000)
    };

    // Bench-side model
    logic [DW-1:0] ref_mem [1 << AW];
    int            p1_k, p2_k, p1_t, p2_t;
    logic [AW-1:0] p1_a, p2_a;
    logic [LN-1:0] p1_be, p2_be;
    bit            m_open, m_wr, m_lin;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    int            pat_cnt;
    int            nchk, nerr;
    bit            done;

    function automatic logic [DW-1:0] pat_of(int n);
        logic [63:0] x;
        x = 64'h9E3779B97F4A7C15 * 64'(n + 1);
        return x[DW-1:0] ^ x[63:64-DW];
    endfunction

    task automatic check(bit ok, int tg, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL R%0d %s actual %h expected %h", tg, what, act, exp);
        end
    endtask

    task automatic model_clear();
        p1_k = 0; p2_k = 0; p1_t = 12; p2_t = 12;
        m_open = 0; m_wr = 0; m_lin = 1; m_base = '0; m_cnt = '0;
    endtask

    task automatic run_cycle(vec_t v);
        int            tg, ctag, nk;
        bit            st;
        logic [AW-1:0] na;
        logic [DW-1:0] pv;
        tg   = int'(v[24:21]);
        st   = v[20];
        ctag = st ? tg : p2_t;
        // data-phase checks for the cycle now starting
        if (p2_k == 1) begin
            check(d_oe === 1'b1, ctag, "bus driven", DW'(d_oe), DW'(1));
            check(d_out === ref_mem[p2_a], ctag, "read data", d_out, ref_mem[p2_a]);
        end else begin
            check(d_oe === 1'b0, ctag, "bus off", DW'(d_oe), DW'(0));
        end
        clk_en_n   = st;
        chip_sel_n = v[19:17];
        adv        = v[16];
        wr_n       = v[15];
        seq_lin    = v[14];
        addr       = v[13:4];
        lane_we_n  = v[3:0];
        pv         = pat_of(pat_cnt);
        d_in       = (p2_k == 2) ? (st ? ~pv : pv) : '0;
        @(posedge clk);
        if (!st) begin
            nk = 0; na = addr;
            if (!adv) begin
                if (chip_sel_n == 3'b000) begin
                    nk = wr_n ? 1 : 2;
                    m_open = 1; m_wr = !wr_n; m_base = addr; m_cnt = 2'd0; m_lin = seq_lin;
                end else begin
                    m_open = 0;
                end
            end else if (m_open) begin
                m_cnt = m_cnt + 2'd1;
                na = {m_base[AW-1:2], m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
                nk = m_wr ? 2 : 1;
            end
            if (p2_k == 2) begin
                for (int i = 0; i < LN; i++)
                    if (p2_be[i]) ref_mem[p2_a][i*LW +: LW] = pv[i*LW +: LW];
                pat_cnt++;
            end
            p2_k = p1_k; p2_a = p1_a; p2_be = p1_be; p2_t = p1_t;
            p1_k = nk;   p1_a = na;   p1_be = ~lane_we_n; p1_t = tg;
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        clk_en_n = 0; chip_sel_n = 3'b111; adv = 0; wr_n = 1; lane_we_n = '1; d_in = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual %0d cycles expected completion", 20000);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        nchk = 0; nerr = 0; pat_cnt = 0; done = 0;
        model_clear();
        idle_inputs();
        @(negedge clk); @(negedge clk);
        check(d_oe === 1'b0, 12, "bus off in reset", DW'(d_oe), DW'(0)); // R12
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) run_cycle(TBL[i]);

        // R6: asynchronous output enable during a read data phase
        run_cycle(v_ld(6, 0, 10'h012, 1, 4'hF));
        run_cycle(v_sel(6, 3'b111, 10'h000));
        out_en_n = 1'b1; #1;
        check(d_oe === 1'b0, 6, "forced off", DW'(d_oe), DW'(0));
        out_en_n = 1'b0; #1;
        check(d_oe === 1'b1, 6, "drive restored", DW'(d_oe), DW'(1));

        // R12: asynchronous reset while a read is on the bus
        rst_n = 1'b0; #1;
        check(d_oe === 1'b0, 12, "reset drops drive", DW'(d_oe), DW'(0));
        model_clear();
        idle_inputs();
        @(negedge clk);
        rst_n = 1'b1;

        // R11: advance with no open burst after reset
        run_cycle(v_adv(11, 4'h0, 1'b1));
        run_cycle(v_adv(11, 4'h0, 1'b0));
        run_cycle(v_sel(11, 3'b111, 10'h000));
        run_cycle(v_sel(11, 3'b111, 10'h000));
        run_cycle(v_sel(11, 3'b111, 10'h000));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule